// File: doc/BRIEF.md
# Queued IR Mark/Space Sequencer

This block turns a queue of interval commands into the final infrared output waveform. Each 13-bit command word describes one interval. A mark gates the incoming carrier onto the output. A space holds the output low. Every word also carries its own timebase and a length. The block holds up to 128 words. It pops them one after another with no gap between intervals, so a long waveform plays without a break as long as the queue is kept topped up.

Software refills the queue in bursts. It programs a fill threshold and an interrupt enable. A pending flag sets whenever an interval start leaves the queue at or below the threshold. Software clears the flag with a one-cycle clear pulse, then writes at most 128 minus threshold further words. The carrier waveform and a one-cycle pulse per carrier period come from an external modulation generator. The sequencer runs only while the transmit enable is high. Dropping the enable empties the queue and cuts off the current interval.

Top module: `ir_seq_tx`

## Requirements
- R1: After reset, ir_out, busy, pend, irq and ovf are 0, level is 0, and cmd_ready is 0 while tx_en is low.
- R2: A word is taken on a clock edge where cmd_valid and cmd_ready are both high. cmd_ready is high exactly when tx_en is high and fewer than 128 words are queued. Each word taken raises level by one, unless a word is popped in the same cycle.
- R3: A word with bit 12 set is a mark. While a mark interval is active, ir_out follows car_in.
- R4: A word with bit 12 clear is a space. During a space interval, busy is high and ir_out is low.
- R5: Bits 11:10 select the timebase and bits 9:0 hold the length minus one. Timebase codes 0, 1 and 2 select 1, 10 and 100 µs units. An interval with length field n under these codes lasts exactly (n+1)*unit clock cycles, where one µs is CYC_PER_US cycles.
- R6: Timebase code 3 measures the interval in carrier periods. The interval ends on the (n+1)-th car_tick pulse that it sees.
- R7: The next queued word starts in the cycle right after the current interval ends, so busy stays high across the chain. Once the queue is empty and the last interval has ended, busy and ir_out are low.
- R8: A word offered with cmd_valid while the queue is full and tx_en is high is dropped. level stays at 128, and the sticky ovf flag sets and stays set until reset.
- R9: With irq_en high, pend sets on any clock edge where a word is popped and the resulting level is at or below thresh.
- R10: A pend_clr pulse clears pend. If a set condition falls in the same cycle as pend_clr, the set wins.
- R11: irq equals pend AND irq_en. With irq_en low, pend does not set.
- R12: When tx_en goes low, the queue is emptied and the active interval is aborted. level, busy and ir_out are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; low flushes and aborts |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Queue can take a word |
| cmd_data | input | 13 | Command: bit 12 mark, bits 11:10 timebase, bits 9:0 length minus one |
| car_in | input | 1 | Carrier waveform from the modulation generator |
| car_tick | input | 1 | One-cycle pulse per carrier period |
| irq_en | input | 1 | Fill-level interrupt enable |
| thresh | input | 8 | Fill threshold |
| pend_clr | input | 1 | Write-to-clear pulse for pend |
| ir_out | output | 1 | Final IR output |
| busy | output | 1 | An interval is playing |
| level | output | 8 | Words queued |
| pend | output | 1 | Threshold pending flag |
| irq | output | 1 | Interrupt request |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The set and the clear of the pending flag can land on the same edge. This happens when an interval start pops a word while software's clear pulse is still high. The bench holds pend_clr high for a whole chain of short intervals. Since a set must win, pend has to show exactly one high cycle per pop. Interval end and the next pop also share a cycle, and the bench judges that by requiring the measured busy time of a chain to equal the sum of its interval lengths, with only one falling edge of busy.

// File: rtl/ir_seq_pkg.sv
package ir_seq_pkg;
  localparam int CMD_W = 13;
  localparam int LEN_W = 10;

  typedef enum logic [1:0] {
    TB_1US     = 2'd0,
    TB_10US    = 2'd1,
    TB_100US   = 2'd2,
    TB_CARRIER = 2'd3
  } tbase_e;

  typedef struct packed {
    logic             mark;
    tbase_e           tb;
    logic [LEN_W-1:0] len_m1;
  } cmd_t;
endpackage

// File: rtl/ir_cmd_fifo.sv
module ir_cmd_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 13,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_nxt
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign rdata = mem[rd_ptr];

  always_comb begin
    level_nxt = level;
    if (flush) level_nxt = '0;
    else if (push && !pop) level_nxt = level + 1'b1;
    else if (!push && pop) level_nxt = level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      level <= level_nxt;
    end
  end

  a_r8_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  a_r2_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> level == $past(level) + 1'b1);
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
endmodule

// File: rtl/ir_interval_timer.sv
module ir_interval_timer
  import ir_seq_pkg::*;
#(
  parameter int CYC_PER_US = 200,
  localparam int MAX_UNIT = CYC_PER_US * 100,
  localparam int PRE_W    = $clog2(MAX_UNIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic load,
  input  cmd_t cmd_in,
  input  logic car_tick,
  output logic active,
  output logic mark,
  output logic fin
);
  tbase_e             tb_q;
  logic [LEN_W-1:0]   units;
  logic [PRE_W-1:0]   presc;
  logic [PRE_W-1:0]   unit_len;
  logic               unit_done;

  always_comb begin
    unit_len = PRE_W'(CYC_PER_US);
    case (tb_q)
      TB_1US:   unit_len = PRE_W'(CYC_PER_US);
      TB_10US:  unit_len = PRE_W'(CYC_PER_US * 10);
      TB_100US: unit_len = PRE_W'(CYC_PER_US * 100);
      default:  unit_len = PRE_W'(CYC_PER_US);
    endcase
  end

  assign unit_done = active && ((tb_q == TB_CARRIER) ? car_tick
                                                     : (presc == unit_len - 1'b1));
  assign fin = unit_done && (units == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      mark   <= 1'b0;
      tb_q   <= TB_1US;
      units  <= '0;
      presc  <= '0;
    end else if (abort) begin
      active <= 1'b0;
      presc  <= '0;
    end else if (load) begin
      active <= 1'b1;
      mark   <= cmd_in.mark;
      tb_q   <= cmd_in.tb;
      units  <= cmd_in.len_m1;
      presc  <= '0;
    end else if (unit_done) begin
      presc <= '0;
      if (units == '0) active <= 1'b0;
      else units <= units - 1'b1;
    end else if (active && tb_q != TB_CARRIER) begin
      presc <= presc + 1'b1;
    end
  end

  a_r7_chain_start: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort) |=> active);
  a_r12_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active);
  a_r5_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tb_q != TB_CARRIER) |-> presc < unit_len);
  a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !load && !abort) |=> !active);
endmodule

// File: rtl/ir_fill_irq.sv
module ir_fill_irq #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_en,
  input  logic             pop,
  input  logic [LVL_W-1:0] level_nxt,
  input  logic [LVL_W-1:0] thresh,
  input  logic             pend_clr,
  output logic             pend,
  output logic             irq
);
  logic set_evt;

  assign set_evt = irq_en && pop && (level_nxt <= thresh);
  assign irq     = pend && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (set_evt)  pend <= 1'b1;
    else if (pend_clr) pend <= 1'b0;
  end

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !set_evt) |=> !pend);
  a_r11_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !pend) |=> !pend);
endmodule

// File: rtl/ir_seq_tx.sv
module ir_seq_tx
  import ir_seq_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int CYC_PER_US = 200,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             car_in,
  input  logic             car_tick,
  input  logic             irq_en,
  input  logic [LVL_W-1:0] thresh,
  input  logic             pend_clr,
  output logic             ir_out,
  output logic             busy,
  output logic [LVL_W-1:0] level,
  output logic             pend,
  output logic             irq,
  output logic             ovf
);
  logic             full, empty, push, pop, active, mark, fin;
  logic [CMD_W-1:0] head;
  logic [LVL_W-1:0] level_nxt;
  cmd_t             head_cmd;

  assign cmd_ready = tx_en && !full;
  assign push      = cmd_valid && cmd_ready;
  assign pop       = tx_en && !empty && (!active || fin);
  assign head_cmd  = cmd_t'(head);

  ir_cmd_fifo #(.DEPTH(DEPTH), .W(CMD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en), .push(push), .wdata(cmd_data),
    .pop(pop), .rdata(head), .full(full), .empty(empty),
    .level(level), .level_nxt(level_nxt)
  );

  ir_interval_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .abort(!tx_en), .load(pop), .cmd_in(head_cmd),
    .car_tick(car_tick), .active(active), .mark(mark), .fin(fin)
  );

  ir_fill_irq #(.LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .pop(pop),
    .level_nxt(level_nxt), .thresh(thresh), .pend_clr(pend_clr),
    .pend(pend), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else if (cmd_valid && tx_en && full) ovf <= 1'b1;
  end

  assign busy   = active;
  assign ir_out = active && mark && car_in;

  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ir_out);
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  a_r12_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (level == '0));
endmodule

// File: tb/tb_ir_seq_tx.sv
`timescale 1ns/1ps
module tb_ir_seq_tx;
  localparam int CPU   = 2;
  localparam int DEPTH = 128;

  logic clk = 0, rst_n = 0, tx_en = 0, cmd_valid = 0, car_in = 1, car_tick = 0;
  logic irq_en = 0, pend_clr = 0;
  logic [12:0] cmd_data = '0;
  logic [7:0]  thresh = '0;
  logic cmd_ready, ir_out, busy, pend, irq, ovf;
  logic [7:0] level;

  int checks = 0, failures = 0;
  int mon_busy = 0, mon_ir = 0, mon_tick = 0, mon_pend = 0, mon_fall = 0;
  int tick_cnt = 0;
  bit done = 0;
  logic busy_d = 0;

  always #2.5 clk = ~clk;

  ir_seq_tx #(.DEPTH(DEPTH), .CYC_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .car_in(car_in),
    .car_tick(car_tick), .irq_en(irq_en), .thresh(thresh), .pend_clr(pend_clr),
    .ir_out(ir_out), .busy(busy), .level(level), .pend(pend), .irq(irq), .ovf(ovf)
  );

  always @(negedge clk) begin
    tick_cnt = (tick_cnt == 6) ? 0 : tick_cnt + 1;
    car_tick = (tick_cnt == 0);
  end

  always @(posedge clk) begin
    if (busy) mon_busy++;
    if (ir_out) mon_ir++;
    if (busy && car_tick) mon_tick++;
    if (pend) mon_pend++;
    if (busy_d && !busy) mon_fall++;
    busy_d <= busy;
  end

  function automatic int unit_cyc(input int tb);
    case (tb)
      0: return CPU;
      1: return CPU * 10;
      default: return CPU * 100;
    endcase
  endfunction

  function automatic int dur(input int tb, input int n);
    return (n + 1) * unit_cyc(tb);
  endfunction

  function automatic logic [12:0] word(input bit m, input int tb, input int n);
    return {m, 2'(tb), 10'(n)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [12:0] w);
    cmd_valid = 1; cmd_data = w;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic clr_mon();
    mon_busy = 0; mon_ir = 0; mon_tick = 0; mon_pend = 0; mon_fall = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy && level == 0) break;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int exp_b, exp_i;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!ir_out && !busy && !pend && !irq && !ovf, "R1 outputs idle", {ir_out,busy,pend,irq,ovf}, 0);
    chk(level == 0, "R1 level", level, 0);
    chk(!cmd_ready, "R1 ready low while disabled", cmd_ready, 0);
    tx_en = 1;
    @(negedge clk);

    // R3 R5 mark, 1 us timebase
    clr_mon(); push(word(1, 0, 3)); wait_idle();
    chk(mon_busy == dur(0, 3), "R5 tb0 duration", mon_busy, dur(0, 3));
    chk(mon_ir == dur(0, 3), "R3 mark follows carrier", mon_ir, dur(0, 3));
    // R4 R5 space, 10 us
    clr_mon(); push(word(0, 1, 2)); wait_idle();
    chk(mon_busy == dur(1, 2), "R5 tb1 duration", mon_busy, dur(1, 2));
    chk(mon_ir == 0, "R4 space output low", mon_ir, 0);
    // R5 100 us
    clr_mon(); push(word(0, 2, 0)); wait_idle();
    chk(mon_busy == dur(2, 0), "R5 tb2 duration", mon_busy, dur(2, 0));
    // R6 carrier timebase
    clr_mon(); push(word(1, 3, 2)); wait_idle();
    chk(mon_tick == 3, "R6 carrier periods", mon_tick, 3);
    // R3 with carrier low: output must stay low
    car_in = 0;
    clr_mon(); push(word(1, 0, 5)); wait_idle();
    chk(mon_ir == 0 && mon_busy == dur(0, 5), "R3 carrier gated off", mon_ir, 0);
    car_in = 1;
    // R7 back-to-back chain
    clr_mon();
    push(word(1, 0, 1)); push(word(0, 0, 3)); push(word(1, 1, 0));
    wait_idle();
    chk(mon_busy == 32, "R7 chain total", mon_busy, 32);
    chk(mon_ir == 24, "R7 chain marks", mon_ir, 24);
    chk(mon_fall == 1, "R7 no gap", mon_fall, 1);
    chk(!busy && !ir_out, "R7 idle after empty", {busy, ir_out}, 0);

    // random sequence
    clr_mon(); exp_b = 0; exp_i = 0;
    for (int k = 0; k < 20; k++) begin
      bit m = 1'($urandom);
      int tb = int'($urandom % 2);
      int n = int'($urandom % 16);
      exp_b += dur(tb, n);
      if (m) exp_i += dur(tb, n);
      push(word(m, tb, n));
    end
    wait_idle();
    chk(mon_busy == exp_b, "R5 R7 random busy total", mon_busy, exp_b);
    chk(mon_ir == exp_i, "R3 R4 random mark total", mon_ir, exp_i);

    // R10 clear held through pops: set wins, one pend cycle per pop
    irq_en = 1; thresh = 8'd127; pend_clr = 1;
    clr_mon();
    push(word(0, 0, 0)); push(word(0, 0, 0)); push(word(0, 0, 0));
    wait_idle();
    chk(mon_pend == 3, "R10 set beats clear", mon_pend, 3);
    chk(!pend, "R10 cleared at end", pend, 0);
    pend_clr = 0;
    // R9 R11 threshold set
    thresh = 8'd2;
    push(word(0, 0, 0)); push(word(0, 0, 0));
    wait_idle();
    chk(pend && irq, "R9 pend and irq set", {pend, irq}, 3);
    irq_en = 0;
    @(negedge clk);
    chk(pend && !irq, "R11 irq gated by enable", {pend, irq}, 2);
    pend_clr = 1; @(negedge clk); pend_clr = 0;
    chk(!pend, "R10 clear pulse", pend, 0);
    push(word(0, 0, 0)); push(word(0, 0, 0));
    wait_idle();
    chk(!pend && !irq, "R11 no set when disabled", {pend, irq}, 0);

    // R2 R8 fill, overflow; R12 flush
    push(word(1, 2, 10));
    @(negedge clk);
    for (int k = 0; k < DEPTH; k++) push(word(0, 0, 0));
    chk(level == 8'(DEPTH), "R2 level after fill", level, DEPTH);
    chk(!cmd_ready && !ovf, "R2 ready low when full", {cmd_ready, ovf}, 0);
    push(word(0, 0, 7));
    chk(ovf && level == 8'(DEPTH), "R8 overflow dropped", level, DEPTH);
    chk(busy && ir_out, "R3 long mark running", {busy, ir_out}, 3);
    tx_en = 0;
    @(negedge clk);
    chk(level == 0 && !busy && !ir_out, "R12 flush and abort", level, 0);
    chk(ovf, "R8 overflow sticky", ovf, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule